// File: doc/BRIEF.md
# I/Q Imbalance Image-Rejection Calibrator

This block sits after the decimating low-pass filters of a low-IF receiver. It corrects the gain and phase mismatch between the I and Q sample streams before the samples go on to the per-path band-pass filters and the demodulator. The Q stream passes through a two-tap fractional-delay interpolator and then a signed gain multiplier. The I stream passes through a fixed half-sample interpolator, which matches the latency of the Q path at its nominal setting. Both paths then leave through a common two-stage pipeline.

A pulse on `cal_start` begins a background calibration. While it runs, the block drives a synthetic image tone at one quarter of the sample rate on `tone_i`/`tone_q`, which is meant to be injected upstream of the analog mixer. The tone comes back through the analog path with that path's imbalance on it. An image detector folds the corrected pair into two image-residual terms and integrates their squared sum over a window of samples, saturating at full scale. A controller runs alternating coordinate descent on the gain and delay settings. It keeps each trial step that lowers the energy. A step that does not is undone, and that axis's step is reversed and halved. The loop stops when both steps have shrunk to one LSB or when its iteration budget runs out. It then raises `cal_done` and holds the settings until the next `cal_start`.

Top module: `iq_image_cal`

## Requirements
- R1: While reset is held, and after it until the first input, `out_valid`, `cal_done`, `tone_i` and `tone_q` are all zero.
- R2: `out_valid` is high exactly two clock cycles after a cycle with `in_valid` high, and low otherwise.
- R3: With the settings after reset (gain 0x4000 meaning 1.0 with 14 fraction bits, delay coefficient 2048 of 4096), each output is floor((x[n] + x[n-1]) / 2) of its own input stream, where x[n-1] is the previous valid sample and is 0 after reset.
- R4: While calibrating, the tone pair steps through (A,0), (0,-A), (-A,0), (0,A), where A is TONE_AMP. It starts at (A,0) in the cycle after `cal_start` and moves on one entry per `in_valid`. Outside calibration both tone outputs are zero.
- R5: A `cal_start` pulse restarts calibration from the reset settings in any state, and `cal_done` is low in the next cycle.
- R6: With `in_valid` high every cycle, `cal_done` rises within (MAX_ITER+1)·(ACC_LEN+6) cycles of `cal_start`. No more than MAX_ITER trial steps follow the baseline measurement.
- R7: For a pure Q gain error of 0.9, the image residual energy after calibration is at least 100 times smaller than it is with the reset settings.
- R8: For a Q gain error of 1.05 combined with a 0.1-sample Q delay error, the residual energy after calibration is at least 20 times smaller than it is with the reset settings.
- R9: Once `cal_done` is high, it and the correction settings stay unchanged until the next `cal_start`. Repeated measurements of the residual therefore agree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample pair is valid |
| in_i | input | W | Decimated I sample, signed |
| in_q | input | W | Decimated Q sample, signed |
| cal_start | input | 1 | Pulse that starts (or restarts) calibration |
| out_valid | output | 1 | Corrected sample pair is valid |
| out_i | output | W | Delay-matched I sample |
| out_q | output | W | Delay- and gain-corrected Q sample |
| tone_i | output | W | Synthetic image tone, I rail |
| tone_q | output | W | Synthetic image tone, Q rail |
| cal_done | output | 1 | Calibration finished; settings locked |

## Verification
The bench builds the block with W=16, TONE_AMP=8192 and MAX_ITER=64, but with ACC_LEN cut from 1024 to 64. The shorter window keeps every trial step to about seventy cycles, so two full calibrations of 65 measurements each fit easily in the run. The tone amplitude keeps rounding noise in the residual small against a 20 dB improvement. A full-length iteration budget also means that convergence on both the gain axis and the delay axis is exercised at the same step resolution that the default build uses.

// File: rtl/iqcal_pkg.sv
// Shared definitions for the I/Q image-rejection calibrator.
// Assumes nothing beyond standard SystemVerilog packages.
package iqcal_pkg;

    // Controller phases of one calibration run
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_MEAS,
        ST_DECIDE,
        ST_DONE
    } cal_state_e;

    // Output samples discarded after a settings change before integrating:
    // two pipeline stages plus one detector history register, plus margin.
    localparam int SETTLE_SMP = 4;

endpackage

// File: rtl/iqcal_corrector.sv
// Correction datapath. Q is linearly interpolated between the current and
// the previous sample with coefficient dly/2^DLY_W and then scaled by gain
// (unity at 2^(GAIN_W-2)) with saturation. I is averaged over the same two
// taps, which matches Q at the nominal coefficient of one half.
// Assumes gain and dly change only between samples that it may discard.
module iqcal_corrector #(
    parameter int W      = 16,
    parameter int GAIN_W = 16,
    parameter int DLY_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [W-1:0]      in_i,
    input  logic signed [W-1:0]      in_q,
    input  logic signed [GAIN_W-1:0] gain,
    input  logic [DLY_W-1:0]         dly,
    output logic                     out_valid,
    output logic signed [W-1:0]      out_i,
    output logic signed [W-1:0]      out_q
);
    localparam int PW = W + DLY_W + 3;
    localparam int MW = W + GAIN_W;
    localparam logic signed [DLY_W+1:0] C_FULL = (DLY_W+2)'(1 << DLY_W);
    localparam logic signed [W+1:0]     Q_HI   = (W+2)'((1 << (W-1)) - 1);
    localparam logic signed [W+1:0]     Q_LO   = -Q_HI - 1;

    logic signed [W-1:0]     i_prev, q_prev, i_s1, q_s1, q_sat;
    logic                    v1;
    logic signed [DLY_W+1:0] c_old, c_now;
    logic signed [PW-1:0]    q_mix;
    logic signed [W:0]       i_sum;
    logic signed [MW-1:0]    q_scaled;
    logic signed [W+1:0]     q_shift;

    // Interpolation and gain arithmetic for both paths
    always_comb begin
        c_old    = signed'({2'b00, dly});
        c_now    = C_FULL - c_old;
        q_mix    = PW'(in_q) * PW'(c_now) + PW'(q_prev) * PW'(c_old);
        i_sum    = (W+1)'(in_i) + (W+1)'(i_prev);
        q_scaled = MW'(q_s1) * MW'(gain);
        q_shift  = (W+2)'(q_scaled >>> (GAIN_W-2));
        if (q_shift > Q_HI)      q_sat = W'(Q_HI);
        else if (q_shift < Q_LO) q_sat = W'(Q_LO);
        else                     q_sat = W'(q_shift);
    end

    // Stage 1: tap history and interpolated samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_prev <= '0; q_prev <= '0; i_s1 <= '0; q_s1 <= '0; v1 <= 1'b0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                i_prev <= in_i;
                q_prev <= in_q;
                i_s1   <= i_sum[W:1];
                q_s1   <= W'(q_mix >>> DLY_W);
            end
        end
    end

    // Stage 2: gain-corrected output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_i <= '0; out_q <= '0;
        end else begin
            out_valid <= v1;
            if (v1) begin
                out_i <= i_s1;
                out_q <= q_sat;
            end
        end
    end

    // R2: outputs only move when a sample leaves stage 1
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !v1 |=> ($stable(out_i) && $stable(out_q)));

endmodule

// File: rtl/iqcal_tone.sv
// Image-tone generator at a quarter of the sample rate, image side
// (Q lags I by a quarter turn in the negative sense). Zero when inactive.
// Assumes start and adv are never high together in normal use; start wins.
module iqcal_tone #(
    parameter int W   = 16,
    parameter int AMP = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                active,
    input  logic                adv,
    output logic signed [W-1:0] tone_i,
    output logic signed [W-1:0] tone_q
);
    localparam logic signed [W-1:0] T_POS = W'(AMP);
    localparam logic signed [W-1:0] T_NEG = -T_POS;

    logic [1:0] phase;

    // Phase counter, restarted by start, advanced per consumed sample
    always_ff @(posedge clk) begin
        if (!rst_n)               phase <= 2'd0;
        else if (start)           phase <= 2'd0;
        else if (active && adv)   phase <= phase + 2'd1;
    end

    // Quadrant lookup
    always_comb begin
        tone_i = '0;
        tone_q = '0;
        if (active) begin
            case (phase)
                2'd0: tone_i = T_POS;
                2'd1: tone_q = T_NEG;
                2'd2: tone_i = T_NEG;
                default: tone_q = T_POS;
            endcase
        end
    end

    // R4: while active exactly one rail carries the tone
    a_r4_one_rail: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((tone_i == '0) != (tone_q == '0)));

endmodule

// File: rtl/iqcal_detector.sv
// Image detector. Folds the corrected pair into the two residual terms
// i[n-1]+q[n] and i[n]-q[n-1], which vanish for a balanced quarter-rate
// image tone, and integrates their squared sum with saturation.
// Assumes ACC_W exceeds 2*W+2 so one term never saturates alone.
module iqcal_detector #(
    parameter int W     = 16,
    parameter int ACC_W = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic signed [W-1:0] ci,
    input  logic signed [W-1:0] cq,
    input  logic                clr,
    input  logic                en,
    output logic [ACC_W-1:0]    energy
);
    localparam int RW  = W + 1;
    localparam int SQW = 2 * RW;

    logic signed [W-1:0]   ci_prev, cq_prev;
    logic signed [RW-1:0]  r_a, r_b;
    logic signed [SQW-1:0] sq_a, sq_b;
    logic [SQW:0]          pwr;
    logic [ACC_W:0]        sum;

    // Residual terms, their power, and the widened running sum
    always_comb begin
        r_a  = RW'(ci_prev) + RW'(cq);
        r_b  = RW'(ci) - RW'(cq_prev);
        sq_a = SQW'(r_a) * SQW'(r_a);
        sq_b = SQW'(r_b) * SQW'(r_b);
        pwr  = {1'b0, sq_a} + {1'b0, sq_b};
        sum  = {1'b0, energy} + (ACC_W+1)'(pwr);
    end

    // Sample history for the one-sample quadrature shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ci_prev <= '0; cq_prev <= '0;
        end else if (smp_valid) begin
            ci_prev <= ci; cq_prev <= cq;
        end
    end

    // Saturating accumulator
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  energy <= '0;
        else if (en)        energy <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
    end

    // R7: integration never wraps downward
    a_r7_energy_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (energy >= $past(energy)));

endmodule

// File: rtl/iqcal_ctrl.sv
// Calibration controller. Measures a baseline, then alternates trial steps
// on gain and delay. A trial that lowers the energy is kept; otherwise that
// axis reverts and its step is reversed and halved (never below one LSB).
// Ends when both steps are one LSB or after MAX_ITER trials.
// Assumes smp_valid marks corrected samples and energy is the detector sum.
module iqcal_ctrl
    import iqcal_pkg::*;
#(
    parameter int GAIN_W   = 16,
    parameter int DLY_W    = 12,
    parameter int ACC_W    = 40,
    parameter int ACC_LEN  = 1024,
    parameter int MAX_ITER = 64,
    parameter int STEP_G0  = 256,
    parameter int STEP_D0  = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     smp_valid,
    input  logic [ACC_W-1:0]         energy,
    output logic signed [GAIN_W-1:0] gain,
    output logic [DLY_W-1:0]         dly,
    output logic                     busy,
    output logic                     done,
    output logic                     det_clr,
    output logic                     det_en
);
    localparam int CNT_W = $clog2(ACC_LEN + SETTLE_SMP + 1);
    localparam int IT_W  = $clog2(MAX_ITER + 1);
    localparam logic signed [GAIN_W-1:0] G_ONE  = GAIN_W'(1 << (GAIN_W-2));
    localparam logic [DLY_W-1:0]         D_HALF = DLY_W'(1 << (DLY_W-1));
    localparam logic signed [GAIN_W:0]   G_HI   = (GAIN_W+1)'((1 << (GAIN_W-1)) - 1);
    localparam logic signed [GAIN_W:0]   G_LO   = -G_HI - 1;
    localparam logic signed [DLY_W+1:0]  D_HI   = (DLY_W+2)'((1 << DLY_W) - 1);

    cal_state_e                state_q;
    logic [CNT_W-1:0]          cnt_q;
    logic signed [GAIN_W-1:0]  gbase_q, sg_q, gkeep, sg_n, gain_n;
    logic [DLY_W-1:0]          dbase_q, dkeep, dly_n;
    logic signed [DLY_W:0]     sd_q, sd_n;
    logic                      axis_q, axis_n, base_q, fin;
    logic [ACC_W-1:0]          best_q, best_n;
    logic [IT_W-1:0]           iter_q;

    function automatic logic signed [GAIN_W-1:0] halve_g(input logic signed [GAIN_W-1:0] s);
        if (s == 1 || s == -1) return -s;
        return -(s >>> 1);
    endfunction

    function automatic logic signed [DLY_W:0] halve_d(input logic signed [DLY_W:0] s);
        if (s == 1 || s == -1) return -s;
        return -(s >>> 1);
    endfunction

    function automatic logic signed [GAIN_W-1:0] add_g(input logic signed [GAIN_W-1:0] g,
                                                       input logic signed [GAIN_W-1:0] s);
        logic signed [GAIN_W:0] t;
        t = (GAIN_W+1)'(g) + (GAIN_W+1)'(s);
        if (t > G_HI) t = G_HI;
        if (t < G_LO) t = G_LO;
        return t[GAIN_W-1:0];
    endfunction

    function automatic logic [DLY_W-1:0] add_d(input logic [DLY_W-1:0] d,
                                               input logic signed [DLY_W:0] s);
        logic signed [DLY_W+1:0] t;
        t = signed'({2'b00, d}) + (DLY_W+2)'(s);
        if (t > D_HI) t = D_HI;
        if (t < 0)    t = '0;
        return t[DLY_W-1:0];
    endfunction

    // Decision logic: keep or revert the trial, then pick the next trial
    always_comb begin
        gkeep  = gain;
        dkeep  = dly;
        sg_n   = sg_q;
        sd_n   = sd_q;
        best_n = best_q;
        if (base_q || energy < best_q) begin
            best_n = energy;
        end else if (!axis_q) begin
            gkeep = gbase_q;
            sg_n  = halve_g(sg_q);
        end else begin
            dkeep = dbase_q;
            sd_n  = halve_d(sd_q);
        end
        axis_n = base_q ? 1'b0 : !axis_q;
        fin    = !base_q && ((iter_q == IT_W'(MAX_ITER - 1)) ||
                             ((sg_n == 1 || sg_n == -1) && (sd_n == 1 || sd_n == -1)));
        gain_n = gkeep;
        dly_n  = dkeep;
        if (!fin) begin
            if (!axis_n) gain_n = add_g(gkeep, sg_n);
            else         dly_n  = add_d(dkeep, sd_n);
        end
    end

    // Sequencer and settings registers
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            state_q <= rst_n ? ST_SETTLE : ST_IDLE;
            cnt_q   <= '0;
            gain    <= G_ONE;  gbase_q <= G_ONE;
            dly     <= D_HALF; dbase_q <= D_HALF;
            sg_q    <= GAIN_W'(STEP_G0);
            sd_q    <= (DLY_W+1)'(STEP_D0);
            axis_q  <= 1'b0;
            base_q  <= 1'b1;
            best_q  <= '0;
            iter_q  <= '0;
        end else begin
            case (state_q)
                ST_SETTLE: if (smp_valid) begin
                    if (cnt_q == CNT_W'(SETTLE_SMP - 1)) begin
                        state_q <= ST_MEAS; cnt_q <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_MEAS: if (smp_valid) begin
                    if (cnt_q == CNT_W'(ACC_LEN - 1)) begin
                        state_q <= ST_DECIDE; cnt_q <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_DECIDE: begin
                    state_q <= fin ? ST_DONE : ST_SETTLE;
                    gain    <= gain_n;  gbase_q <= gkeep;
                    dly     <= dly_n;   dbase_q <= dkeep;
                    sg_q    <= sg_n;    sd_q    <= sd_n;
                    axis_q  <= axis_n;  best_q  <= best_n;
                    base_q  <= 1'b0;
                    if (!base_q) iter_q <= iter_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Status decode towards detector, tone and the block boundary
    always_comb begin
        done    = (state_q == ST_DONE);
        busy    = (state_q == ST_SETTLE) || (state_q == ST_MEAS) || (state_q == ST_DECIDE);
        det_clr = (state_q != ST_MEAS);
        det_en  = (state_q == ST_MEAS) && smp_valid;
    end

    // R6: trial budget is never exceeded
    a_r6_iter_cap: assert property (@(posedge clk) disable iff (!rst_n)
        iter_q <= IT_W'(MAX_ITER));

    // R9: locked settings stay put until a restart
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(gain) && $stable(dly)));

    // R5: a restart drops done and starts work
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && busy));

endmodule

// File: rtl/iq_image_cal.sv
// Top of the I/Q imbalance image-rejection calibrator: correction datapath,
// image-tone generator, image detector and descent controller.
// Assumes in_valid is low in the cycle cal_start is pulsed.
module iq_image_cal #(
    parameter int W        = 16,
    parameter int GAIN_W   = 16,
    parameter int DLY_W    = 12,
    parameter int ACC_W    = 40,
    parameter int ACC_LEN  = 1024,
    parameter int MAX_ITER = 64,
    parameter int STEP_G0  = 256,
    parameter int STEP_D0  = 256,
    parameter int TONE_AMP = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    input  logic                cal_start,
    output logic                out_valid,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q,
    output logic signed [W-1:0] tone_i,
    output logic signed [W-1:0] tone_q,
    output logic                cal_done
);
    logic signed [GAIN_W-1:0] gain;
    logic [DLY_W-1:0]         dly;
    logic                     busy, det_clr, det_en;
    logic [ACC_W-1:0]         energy;

    iqcal_corrector #(.W(W), .GAIN_W(GAIN_W), .DLY_W(DLY_W)) u_corr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .gain(gain), .dly(dly), .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

    iqcal_tone #(.W(W), .AMP(TONE_AMP)) u_tone (
        .clk(clk), .rst_n(rst_n), .start(cal_start), .active(busy), .adv(in_valid),
        .tone_i(tone_i), .tone_q(tone_q));

    iqcal_detector #(.W(W), .ACC_W(ACC_W)) u_det (
        .clk(clk), .rst_n(rst_n), .smp_valid(out_valid), .ci(out_i), .cq(out_q),
        .clr(det_clr), .en(det_en), .energy(energy));

    iqcal_ctrl #(.GAIN_W(GAIN_W), .DLY_W(DLY_W), .ACC_W(ACC_W), .ACC_LEN(ACC_LEN),
                 .MAX_ITER(MAX_ITER), .STEP_G0(STEP_G0), .STEP_D0(STEP_D0)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(cal_start), .smp_valid(out_valid),
        .energy(energy), .gain(gain), .dly(dly), .busy(busy), .done(cal_done),
        .det_clr(det_clr), .det_en(det_en));

    // R4: no tone leaves the block once calibration has locked
    a_r4_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> (tone_i == '0 && tone_q == '0));

endmodule

// File: tb/test_iq_image_cal.sv
module test_iq_image_cal;
    localparam int W = 16, ACC_LEN = 64, MAX_ITER = 64, AMP = 8192;
    localparam int LIMIT = (MAX_ITER + 1) * (ACC_LEN + 6);

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, cal_start = 1'b0;
    logic signed [W-1:0] in_i = '0, in_q = '0;
    logic out_valid, cal_done;
    logic signed [W-1:0] out_i, out_q, tone_i, tone_q;

    always #2 clk = ~clk;

    iq_image_cal #(.W(W), .ACC_LEN(ACC_LEN), .MAX_ITER(MAX_ITER), .TONE_AMP(AMP)) i_iq_image_cal (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cal_start(cal_start), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
        .tone_i(tone_i), .tone_q(tone_q), .cal_done(cal_done));

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tone_ref_i(input int k);
        case (k % 4) 0: return AMP; 2: return -AMP; default: return 0; endcase
    endfunction

    function automatic int tone_ref_q(input int k);
        case (k % 4) 1: return -AMP; 3: return AMP; default: return 0; endcase
    endfunction

    // Analog Q-path imbalance: gain g and fractional delay a, rounded
    function automatic logic signed [W-1:0] imb(input real g, input real a, input real t, input real tp);
        real v;
        v = g * ((1.0 - a) * t + a * tp);
        if (v >= 0.0) return W'($rtoi(v + 0.5));
        return W'(-$rtoi(-v + 0.5));
    endfunction

    // Feed the bench's own image tone through the imbalance, return residual energy
    task automatic run_tone(input real g, input real a, input int n, output real e);
        real tp = 0.0;
        int seen = 0;
        real pi = 0.0, pq = 0.0;
        e = 0.0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (out_valid) begin
                if (seen >= 8)
                    e += (pi + out_q) * (pi + out_q) + (out_i - pq) * (out_i - pq);
                pi = out_i; pq = out_q; seen++;
            end
            in_i = W'(tone_ref_i(c));
            in_q = imb(g, a, real'(tone_ref_q(c)), tp);
            tp = real'(tone_ref_q(c));
            in_valid = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Start calibration and loop the block's own tone through the imbalance
    task automatic calibrate(input real g, input real a);
        real tp = 0.0;
        int cycles = 0;
        @(negedge clk);
        in_valid = 1'b0; cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        check(cal_done == 1'b0, "R5 done low after start", cal_done, 0);
        while (!cal_done && cycles < LIMIT + 20) begin
            if (cycles < 6) begin
                check(tone_i == tone_ref_i(cycles), "R4 tone_i", tone_i, tone_ref_i(cycles));
                check(tone_q == tone_ref_q(cycles), "R4 tone_q", tone_q, tone_ref_q(cycles));
            end
            in_i = tone_i;
            in_q = imb(g, a, real'(tone_q), tp);
            tp = real'(tone_q);
            in_valid = 1'b1;
            @(negedge clk);
            cycles++;
        end
        in_valid = 1'b0;
        check(cal_done == 1'b1, "R6 done reached", cal_done, 1);
        check(cycles <= LIMIT, "R6 done within bound", cycles, LIMIT);
        check(tone_i == 0 && tone_q == 0, "R4 tone silent after done", tone_i, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic signed [W-1:0] exp_i[$], exp_q[$];
        int pi = 0, pq = 0;
        bit vd1 = 0, vd2 = 0;
        int dir_i[8] = '{32767, -32768, 32767, -1, 1, -32768, 12345, 0};
        int dir_q[8] = '{32767, -32768, -32768, 0, -1, 32767, -12346, 0};
        real e0a, e0b, e1a, e2a, e1b;
        void'($urandom(32'h1CA1));

        // R1: reset state
        repeat (4) @(negedge clk);
        check(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
        check(cal_done == 0, "R1 cal_done in reset", cal_done, 0);
        check(tone_i == 0 && tone_q == 0, "R1 tone in reset", tone_i, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && cal_done == 0, "R1 after release", out_valid, 0);

        // R2/R3: reset-setting passthrough, directed extremes then random gaps
        for (int c = 0; c < 260; c++) begin
            @(negedge clk);
            check(out_valid == vd2, "R2 out_valid timing", out_valid, vd2);
            if (out_valid && exp_i.size() > 0) begin
                logic signed [W-1:0] ei, eq;
                ei = exp_i.pop_front(); eq = exp_q.pop_front();
                check(out_i == ei, "R3 out_i", out_i, ei);
                check(out_q == eq, "R3 out_q", out_q, eq);
            end
            vd2 = vd1;
            if (c < 8) begin
                in_valid = 1'b1; in_i = W'(dir_i[c]); in_q = W'(dir_q[c]);
            end else if (c < 250) begin
                in_valid = ($urandom % 10) < 7;
                in_i = W'($urandom); in_q = W'($urandom);
            end else in_valid = 1'b0;
            vd1 = in_valid;
            if (in_valid) begin
                exp_i.push_back(W'((int'(in_i) + pi) >>> 1));
                exp_q.push_back(W'((int'(in_q) + pq) >>> 1));
                pi = in_i; pq = in_q;
            end
        end

        // Residual with reset settings for both imbalance cases
        run_tone(0.9, 0.0, 200, e0a);
        run_tone(1.05, 0.1, 200, e0b);

        // R7: gain-only imbalance
        calibrate(0.9, 0.0);
        run_tone(0.9, 0.0, 200, e1a);
        check(e0a >= 100.0 * e1a, "R7 residual reduction", longint'(e1a), longint'(e0a / 100.0));

        // R9: lock holds, residual repeatable
        check(cal_done == 1'b1, "R9 done still high", cal_done, 1);
        run_tone(0.9, 0.0, 200, e2a);
        check(cal_done == 1'b1, "R9 done held", cal_done, 1);
        check((e2a - e1a) <= 0.01 * e1a + 4.0 && (e1a - e2a) <= 0.01 * e1a + 4.0,
              "R9 residual stable", longint'(e2a), longint'(e1a));

        // R5/R8: restart with gain and delay imbalance
        calibrate(1.05, 0.1);
        run_tone(1.05, 0.1, 200, e1b);
        check(e0b >= 20.0 * e1b, "R8 residual reduction", longint'(e1b), longint'(e0b / 20.0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule